// File: doc/BRIEF.md
# PCM Voice Serial Port

This block carries one voice sample per 8 kHz frame in each direction between a parallel sample interface and a four-wire PCM serial link (bit clock, frame sync, serial in, serial out). Samples to send arrive on a valid/ready pair and sit in a one-entry holding buffer. Each received sample leaves as a 16-bit word with a one-cycle valid strobe.

The link can be mastered by the block or driven from outside. In master mode the block divides the fast system clock down to a 128 kHz or 64 kHz bit clock and generates the frame sync. In slave mode the external clock and sync pins pass through a two-flop synchronizer and edge detector, so the whole port runs on the system clock in both modes. Short-frame sync (a one-bit pulse just before the slot) and long-frame sync (a pulse that starts with the first bit) are both handled. The slot is 8 or 16 bits. A 14-bit sample rides in the upper bits of a 16-bit slot. Each direction has its own mute.

Top module: `pcm_voice_port`

## Requirements
- R1: After reset the clock and sync pins are not driven (both output enables low), serial out is low, no receive strobe is given, and the transmit side is ready.
- R2: In master mode the bit clock period is 2*HALF_DIV system clocks when cfg_fast_clk is 1 and 4*HALF_DIV when it is 0. A frame lasts 16 bit clocks at the fast rate and 8 at the slow rate, so 16-bit slots require the fast rate.
- R3: In master mode the sync changes only together with a rising bit-clock edge. In long-frame mode (cfg_long_frame=1) it is high for 3 bit clocks, starting with the first data bit. In short-frame mode it is high for the single bit clock just before the first data bit.
- R4: Slot bits go out most significant first. Serial out changes after a rising bit-clock edge, and serial in is sampled at the falling edge.
- R5: cfg_width selects the slot layout. 0 sends tx_data[7:0] in an 8-bit slot and ignores tx_data[15:8]. 1 sends {tx_data[13:0],2'b00} in a 16-bit slot. 2 or 3 sends tx_data[15:0] in a 16-bit slot.
- R6: Each received slot produces exactly one single-cycle rx_valid after its last falling edge. rx_data is the two's-complement sample sign-extended to 16 bits: slot[7:0] for 8-bit, slot[15:2] for 14-bit, and the whole slot for 16-bit.
- R7: In slave mode the port follows external clock and sync. A long-frame sync as short as one bit clock starts a slot.
- R8: With cfg_tx_mute high, or with no sample held at frame start, the slot is sent as all zeros.
- R9: With cfg_rx_mute high, a zero sample is delivered with its normal strobe.
- R10: tx_ready is low while a sample is held. A sample offered while it is low is not taken. The held sample is consumed at the start of the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: block drives bit clock and sync |
| cfg_long_frame | input | 1 | 1: long-frame sync, 0: short-frame |
| cfg_fast_clk | input | 1 | Master bit clock rate: 1 = 128 kHz, 0 = 64 kHz |
| cfg_width | input | 2 | Sample layout: 0 = 8-bit, 1 = 14-bit, 2/3 = 16-bit |
| cfg_tx_mute | input | 1 | Send zeros |
| cfg_rx_mute | input | 1 | Deliver zero samples |
| tx_valid | input | 1 | Transmit sample offered |
| tx_data | input | 16 | Transmit sample |
| tx_ready | output | 1 | Holding buffer empty |
| rx_valid | output | 1 | One-cycle strobe for a received sample |
| rx_data | output | 16 | Received sample, sign-extended |
| pcmclk_i | input | 1 | Bit clock from the pin |
| pcmclk_o | output | 1 | Bit clock to the pin |
| pcmclk_oe | output | 1 | Bit clock output enable |
| pcmsync_i | input | 1 | Frame sync from the pin |
| pcmsync_o | output | 1 | Frame sync to the pin |
| pcmsync_oe | output | 1 | Frame sync output enable |
| pcmin | input | 1 | Serial data in |
| pcmout | output | 1 | Serial data out |

## Verification
The bench loops the serial output back to the input in master mode for every sync format, rate and sample width. A design that shifted LSB first, dropped or shifted a bit, or got the 14-bit placement or the sign extension wrong would return a different word. In slave mode the bench acts as an external codec with a one-clock long-frame sync and a short-frame pre-bit, so a slot that starts one bit early or late shows up as a shifted pattern on both pins. It also measures clock period, sync width and frame length. The buffer corners are covered: underrun must send zeros, and a sample offered while the buffer is full must never reach the line.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        WID_8      = 2'd0,
        WID_14     = 2'd1,
        WID_16     = 2'd2,
        WID_16_ALT = 2'd3
    } width_e;

    localparam int SAMPLE_W = 16;
    localparam int CNT_W    = 5;

    function automatic logic [CNT_W-1:0] slot_bits(input logic [1:0] w);
        return (width_e'(w) == WID_8) ? CNT_W'(8) : CNT_W'(16);
    endfunction

    // Left-align a sample into the 16-bit shift word
    function automatic logic [SAMPLE_W-1:0] pack_tx(input logic [SAMPLE_W-1:0] d,
                                                    input logic [1:0] w);
        case (width_e'(w))
            WID_8:   return {d[7:0], 8'h00};
            WID_14:  return {d[13:0], 2'b00};
            default: return d;
        endcase
    endfunction

    // Turn a captured slot into a sign-extended sample
    function automatic logic [SAMPLE_W-1:0] unpack_rx(input logic [SAMPLE_W-1:0] s,
                                                      input logic [1:0] w);
        case (width_e'(w))
            WID_8:   return {{8{s[7]}}, s[7:0]};
            WID_14:  return {{2{s[15]}}, s[15:2]};
            default: return s;
        endcase
    endfunction

endpackage

// File: rtl/pcm_bitclk_gen.sv
module pcm_bitclk_gen #(
    parameter int HALF_DIV        = 488,
    parameter int FAST_FRAME_BITS = 16,
    parameter int SLOW_FRAME_BITS = 8,
    parameter int LONG_SYNC_BITS  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cfg_fast,
    input  logic cfg_long,
    output logic bclk,
    output logic fsync
);
    localparam int DIV_W = $clog2(2 * HALF_DIV);
    localparam int POS_W = $clog2(FAST_FRAME_BITS);
    localparam logic [DIV_W-1:0] LIM_FAST  = DIV_W'(HALF_DIV - 1);
    localparam logic [DIV_W-1:0] LIM_SLOW  = DIV_W'(2 * HALF_DIV - 1);
    localparam logic [POS_W-1:0] LAST_FAST = POS_W'(FAST_FRAME_BITS - 1);
    localparam logic [POS_W-1:0] LAST_SLOW = POS_W'(SLOW_FRAME_BITS - 1);
    localparam logic [POS_W-1:0] SYNC_LEN  = POS_W'(LONG_SYNC_BITS);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             bclk;
        logic [POS_W-1:0] pos;
        logic             fsync;
    } gen_t;

    gen_t gen_q, gen_d;
    logic [DIV_W-1:0] limit;
    logic [POS_W-1:0] last_pos;
    logic [POS_W-1:0] next_pos;

    always_comb begin
        gen_d    = gen_q;
        limit    = cfg_fast ? LIM_FAST : LIM_SLOW;
        last_pos = cfg_fast ? LAST_FAST : LAST_SLOW;
        next_pos = (gen_q.pos == last_pos) ? '0 : gen_q.pos + 1'b1;
        if (!en) begin
            gen_d.div   = '0;
            gen_d.bclk  = 1'b0;
            gen_d.pos   = '1;
            gen_d.fsync = 1'b0;
        end else if (gen_q.div == limit) begin
            gen_d.div  = '0;
            gen_d.bclk = !gen_q.bclk;
            if (!gen_q.bclk) begin
                gen_d.pos   = next_pos;
                gen_d.fsync = cfg_long ? (next_pos < SYNC_LEN) : (next_pos == last_pos);
            end
        end else begin
            gen_d.div = gen_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '{div: '0, bclk: 1'b0, pos: '1, fsync: 1'b0};
        end else begin
            gen_q <= gen_d;
        end
    end

    assign bclk  = gen_q.bclk;
    assign fsync = gen_q.fsync;

    // R2: each bit-clock half lasts at least two system clocks
    a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$stable(gen_q.bclk)) |=> (!en || $stable(gen_q.bclk)));

    // R3: the sync only moves on a rising bit-clock edge
    a_r3_sync_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$stable(gen_q.fsync)) |-> $rose(gen_q.bclk));

endmodule

// File: rtl/pcm_pin_sync.sv
module pcm_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_pin,
    input  logic sync_pin,
    input  logic din_pin,
    output logic bit_rise,
    output logic bit_fall,
    output logic sync_lvl,
    output logic din_lvl
);
    typedef struct packed {
        logic [2:0] stage1;
        logic [2:0] stage2;
        logic       bclk_old;
    } sync_t;

    sync_t sy_q, sy_d;

    always_comb begin
        sy_d          = sy_q;
        sy_d.stage1   = {din_pin, sync_pin, bclk_pin};
        sy_d.stage2   = sy_q.stage1;
        sy_d.bclk_old = sy_q.stage2[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign bit_rise = sy_q.stage2[0] && !sy_q.bclk_old;
    assign bit_fall = !sy_q.stage2[0] && sy_q.bclk_old;
    assign sync_lvl = sy_q.stage2[1];
    assign din_lvl  = sy_q.stage2[2];

    // R7: a detected rising edge is never followed directly by another
    a_r7_rise_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        bit_rise |=> !bit_rise);

endmodule

// File: rtl/pcm_frame_engine.sv
module pcm_frame_engine
    import pcm_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_rise,
    input  logic                bit_fall,
    input  logic                sync_lvl,
    input  logic                din_lvl,
    input  logic                cfg_long,
    input  logic [1:0]          cfg_width,
    input  logic                cfg_tx_mute,
    input  logic                cfg_rx_mute,
    input  logic                tx_valid,
    input  logic [SAMPLE_W-1:0] tx_data,
    output logic                tx_ready,
    output logic                serial_out,
    output logic                rx_valid,
    output logic [SAMPLE_W-1:0] rx_data
);
    typedef struct packed {
        logic                sync_prev;
        logic                tx_act;
        logic [CNT_W-1:0]    tx_cnt;
        logic [SAMPLE_W-1:0] tx_sh;
        logic                out;
        logic                rx_act;
        logic [CNT_W-1:0]    rx_cnt;
        logic [SAMPLE_W-1:0] rx_sh;
        logic                rx_vld;
        logic [SAMPLE_W-1:0] rx_dat;
        logic                buf_full;
        logic [SAMPLE_W-1:0] buf_dat;
    } eng_t;

    eng_t eng_q, eng_d;
    logic [CNT_W-1:0]    slot;
    logic                slot_start;
    logic [SAMPLE_W-1:0] tx_word;
    logic [SAMPLE_W-1:0] rx_word;

    always_comb begin
        eng_d        = eng_q;
        eng_d.rx_vld = 1'b0;
        slot         = slot_bits(cfg_width);
        slot_start   = bit_rise && (cfg_long ? (sync_lvl && !eng_q.sync_prev)
                                             : (!sync_lvl && eng_q.sync_prev));
        tx_word      = (eng_q.buf_full && !cfg_tx_mute) ? pack_tx(eng_q.buf_dat, cfg_width) : '0;
        rx_word      = {eng_q.rx_sh[SAMPLE_W-2:0], din_lvl};

        if (bit_rise) begin
            eng_d.sync_prev = sync_lvl;
        end

        // transmit side: moves on rising edges
        if (slot_start) begin
            eng_d.out      = tx_word[SAMPLE_W-1];
            eng_d.tx_sh    = {tx_word[SAMPLE_W-2:0], 1'b0};
            eng_d.tx_cnt   = CNT_W'(1);
            eng_d.tx_act   = 1'b1;
            eng_d.buf_full = 1'b0;
            eng_d.rx_act   = 1'b1;
            eng_d.rx_cnt   = '0;
        end else if (bit_rise && eng_q.tx_act) begin
            if (eng_q.tx_cnt == slot) begin
                eng_d.out    = 1'b0;
                eng_d.tx_act = 1'b0;
            end else begin
                eng_d.out    = eng_q.tx_sh[SAMPLE_W-1];
                eng_d.tx_sh  = {eng_q.tx_sh[SAMPLE_W-2:0], 1'b0};
                eng_d.tx_cnt = eng_q.tx_cnt + 1'b1;
            end
        end

        // receive side: moves on falling edges
        if (bit_fall && eng_q.rx_act) begin
            eng_d.rx_sh  = rx_word;
            eng_d.rx_cnt = eng_q.rx_cnt + 1'b1;
            if (eng_q.rx_cnt == slot - 1'b1) begin
                eng_d.rx_act = 1'b0;
                eng_d.rx_vld = 1'b1;
                eng_d.rx_dat = cfg_rx_mute ? '0 : unpack_rx(rx_word, cfg_width);
            end
        end

        // one-entry holding buffer
        if (tx_valid && !eng_q.buf_full) begin
            eng_d.buf_full = 1'b1;
            eng_d.buf_dat  = tx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign tx_ready   = !eng_q.buf_full;
    assign serial_out = eng_q.out;
    assign rx_valid   = eng_q.rx_vld;
    assign rx_data    = eng_q.rx_dat;

    // R6: the receive strobe lasts one cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.rx_vld |=> !eng_q.rx_vld);

    // R4: serial out only moves right after a rising edge
    a_r4_out_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(eng_q.out) |-> $past(bit_rise));

    // R9: a muted receive path delivers zero
    a_r9_rx_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.rx_vld && $past(cfg_rx_mute)) |-> (eng_q.rx_dat == '0));

    // R10: the buffer only fills from an offered sample
    a_r10_fill_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.buf_full) |-> $past(tx_valid));

endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
    import pcm_port_pkg::*;
#(
    parameter int HALF_DIV        = 488,
    parameter int FAST_FRAME_BITS = 16,
    parameter int SLOW_FRAME_BITS = 8,
    parameter int LONG_SYNC_BITS  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_master,
    input  logic        cfg_long_frame,
    input  logic        cfg_fast_clk,
    input  logic [1:0]  cfg_width,
    input  logic        cfg_tx_mute,
    input  logic        cfg_rx_mute,
    input  logic        tx_valid,
    input  logic [15:0] tx_data,
    output logic        tx_ready,
    output logic        rx_valid,
    output logic [15:0] rx_data,
    input  logic        pcmclk_i,
    output logic        pcmclk_o,
    output logic        pcmclk_oe,
    input  logic        pcmsync_i,
    output logic        pcmsync_o,
    output logic        pcmsync_oe,
    input  logic        pcmin,
    output logic        pcmout
);
    logic gen_bclk, gen_sync;
    logic bclk_src, sync_src;
    logic bit_rise, bit_fall, sync_lvl, din_lvl;

    pcm_bitclk_gen #(
        .HALF_DIV        (HALF_DIV),
        .FAST_FRAME_BITS (FAST_FRAME_BITS),
        .SLOW_FRAME_BITS (SLOW_FRAME_BITS),
        .LONG_SYNC_BITS  (LONG_SYNC_BITS)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_master),
        .cfg_fast (cfg_fast_clk),
        .cfg_long (cfg_long_frame),
        .bclk     (gen_bclk),
        .fsync    (gen_sync)
    );

    // one timing path for both modes: the master's own pins are looped back
    assign bclk_src = cfg_master ? gen_bclk : pcmclk_i;
    assign sync_src = cfg_master ? gen_sync : pcmsync_i;

    pcm_pin_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_pin (bclk_src),
        .sync_pin (sync_src),
        .din_pin  (pcmin),
        .bit_rise (bit_rise),
        .bit_fall (bit_fall),
        .sync_lvl (sync_lvl),
        .din_lvl  (din_lvl)
    );

    pcm_frame_engine u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_rise    (bit_rise),
        .bit_fall    (bit_fall),
        .sync_lvl    (sync_lvl),
        .din_lvl     (din_lvl),
        .cfg_long    (cfg_long_frame),
        .cfg_width   (cfg_width),
        .cfg_tx_mute (cfg_tx_mute),
        .cfg_rx_mute (cfg_rx_mute),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_ready    (tx_ready),
        .serial_out  (pcmout),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data)
    );

    assign pcmclk_o   = gen_bclk;
    assign pcmsync_o  = gen_sync;
    assign pcmclk_oe  = cfg_master;
    assign pcmsync_oe = cfg_master;

endmodule

// File: tb/pcm_voice_port_test.sv
module pcm_voice_port_test;
    localparam int HD = 4;
    localparam int NV = 11;

    // {long, fast, width, txmute, rxmute, tx, expected rx}
    localparam logic [37:0] VEC [0:NV-1] = '{
        {1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 16'h1234, 16'h1234},
        {1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 16'hFEDC, 16'hFEDC},
        {1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h005A, 16'h005A},
        {1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h00C3, 16'hFFC3},
        {1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 16'h3001, 16'hF001},
        {1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 16'h1FFF, 16'h1FFF},
        {1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 16'hBEEF, 16'h0000},
        {1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 16'h0077, 16'h0000},
        {1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'hAB12, 16'h0012},
        {1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 16'h0081, 16'hFF81},
        {1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 16'h8000, 16'h8000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_master = 1'b0, cfg_long_frame = 1'b0, cfg_fast_clk = 1'b1;
    logic [1:0] cfg_width = 2'd2;
    logic cfg_tx_mute = 1'b0, cfg_rx_mute = 1'b0;
    logic tx_valid = 1'b0;
    logic [15:0] tx_data = '0;
    logic tx_ready, rx_valid;
    logic [15:0] rx_data;
    logic pcmclk_i = 1'b0, pcmsync_i = 1'b0, bench_din = 1'b0;
    logic pcmclk_o, pcmclk_oe, pcmsync_o, pcmsync_oe, pcmout;
    logic loopback = 1'b0;
    logic pcmin_w;

    int checks = 0, errors = 0, cyc = 0, rx_cnt = 0;
    logic [15:0] rx_last = '0;

    assign pcmin_w = loopback ? pcmout : bench_din;

    pcm_voice_port #(.HALF_DIV(HD)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_long_frame(cfg_long_frame),
        .cfg_fast_clk(cfg_fast_clk), .cfg_width(cfg_width), .cfg_tx_mute(cfg_tx_mute),
        .cfg_rx_mute(cfg_rx_mute), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .pcmclk_i(pcmclk_i), .pcmclk_o(pcmclk_o),
        .pcmclk_oe(pcmclk_oe), .pcmsync_i(pcmsync_i), .pcmsync_o(pcmsync_o),
        .pcmsync_oe(pcmsync_oe), .pcmin(pcmin_w), .pcmout(pcmout)
    );

    always #4 clk = !clk;

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt  = rx_cnt + 1;
            rx_last = rx_data;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog (R1..R10 run) actual=%0d cycles expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [15:0] d);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_rx(output bit ok);
        int target = rx_cnt + 1;
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (rx_cnt >= target) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic clk_period(output int n);
        n = 0;
        while (pcmclk_o !== 1'b0) @(negedge clk);
        while (pcmclk_o !== 1'b1) @(negedge clk);
        while (pcmclk_o === 1'b1) begin @(negedge clk); n++; end
        while (pcmclk_o === 1'b0) begin @(negedge clk); n++; end
    endtask

    task automatic sync_shape(output int hi, output int per, output logic clk_at_rise);
        hi = 0;
        per = 0;
        while (pcmsync_o !== 1'b0) @(negedge clk);
        while (pcmsync_o !== 1'b1) @(negedge clk);
        clk_at_rise = pcmclk_o;
        while (pcmsync_o === 1'b1) begin @(negedge clk); hi++; end
        per = hi;
        while (pcmsync_o === 1'b0) begin @(negedge clk); per++; end
    endtask

    // external codec: 16 system clocks per bit, drives on rise, reads on fall
    task automatic slave_frame(input bit lng, input int nbits, input logic [15:0] din,
                               output logic [15:0] seen);
        seen = '0;
        for (int k = -3; k < nbits + 2; k++) begin
            pcmclk_i  = 1'b1;
            pcmsync_i = lng ? (k == 0) : (k == -1);
            bench_din = (k >= 0 && k < nbits) ? din[nbits-1-k] : 1'b0;
            repeat (8) @(negedge clk);
            if (k >= 0 && k < nbits) seen = {seen[14:0], pcmout};
            pcmclk_i = 1'b0;
            repeat (8) @(negedge clk);
        end
    endtask

    initial begin
        bit ok;
        int n, hi, per;
        logic car;
        logic [15:0] seen;

        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 clk oe", {31'b0, pcmclk_oe}, 32'd0);
        check("R1 sync oe", {31'b0, pcmsync_oe}, 32'd0);
        check("R1 pcmout", {31'b0, pcmout}, 32'd0);
        check("R1 rx_valid", {31'b0, rx_valid}, 32'd0);
        check("R1 tx_ready", {31'b0, tx_ready}, 32'd1);

        // table: master loopback (R4 R5 R6 R8 R9 R10)
        cfg_master = 1'b1;
        loopback   = 1'b1;
        for (int v = 0; v < NV; v++) begin
            cfg_long_frame = VEC[v][37];
            cfg_fast_clk   = VEC[v][36];
            cfg_width      = VEC[v][35:34];
            cfg_tx_mute    = VEC[v][33];
            cfg_rx_mute    = VEC[v][32];
            do_reset();
            push(VEC[v][31:16]);
            check("R10 ready low while held", {31'b0, tx_ready}, 32'd0);
            wait_rx(ok);
            check("R6 strobe seen", {31'b0, ok}, 32'd1);
            check("R4/R5/R6/R8/R9 loopback word", {16'b0, rx_last}, {16'b0, VEC[v][15:0]});
        end

        // R2/R3: master timing, fast long
        cfg_long_frame = 1'b1; cfg_fast_clk = 1'b1; cfg_width = 2'd2;
        cfg_tx_mute = 1'b0; cfg_rx_mute = 1'b0;
        do_reset();
        clk_period(n);
        check("R2 fast period", n, 2 * HD);
        sync_shape(hi, per, car);
        check("R3 long sync width", hi, 3 * 2 * HD);
        check("R2 fast frame length", per, 16 * 2 * HD);
        check("R3 sync rises with clk", {31'b0, car}, 32'd1);

        // R2/R3: slow long and fast short
        cfg_fast_clk = 1'b0;
        do_reset();
        clk_period(n);
        check("R2 slow period", n, 4 * HD);
        sync_shape(hi, per, car);
        check("R3 slow long sync width", hi, 3 * 4 * HD);
        check("R2 slow frame length", per, 8 * 4 * HD);
        cfg_fast_clk = 1'b1; cfg_long_frame = 1'b0;
        do_reset();
        sync_shape(hi, per, car);
        check("R3 short sync width", hi, 2 * HD);
        check("R3 short sync rises with clk", {31'b0, car}, 32'd1);

        // R8 underrun, then R10 sample offered while full is dropped
        cfg_long_frame = 1'b1; cfg_width = 2'd0;
        do_reset();
        wait_rx(ok);
        check("R8 underrun sends zeros", {16'b0, rx_last}, 32'd0);
        push(16'h00A1);
        tx_data  = 16'h00B2;
        tx_valid = 1'b1;
        repeat (3) @(negedge clk);
        tx_valid = 1'b0;
        wait_rx(ok);
        check("R10 held sample sent", {16'b0, rx_last}, 32'h0000FFA1);
        wait_rx(ok);
        check("R10 refused sample absent", {16'b0, rx_last}, 32'd0);
        check("R10 ready after consume", {31'b0, tx_ready}, 32'd1);

        // slave mode (R7 R4 R5 R6)
        cfg_master = 1'b0;
        loopback   = 1'b0;
        cfg_long_frame = 1'b1; cfg_width = 2'd2;
        do_reset();
        check("R7 slave clk not driven", {31'b0, pcmclk_oe}, 32'd0);
        push(16'hA5C3);
        slave_frame(1'b1, 16, 16'h8001, seen);
        check("R7 slave long 16 out", {16'b0, seen}, 32'h0000A5C3);
        check("R7 slave long 16 in", {16'b0, rx_last}, 32'h00008001);

        cfg_long_frame = 1'b0; cfg_width = 2'd0;
        do_reset();
        push(16'h003C);
        slave_frame(1'b0, 8, 16'h0096, seen);
        check("R7 slave short 8 out", {16'b0, seen}, 32'h0000003C);
        check("R7 slave short 8 in", {16'b0, rx_last}, 32'h0000FF96);
        check("R4 idle out low", {31'b0, pcmout}, 32'd0);

        cfg_long_frame = 1'b1; cfg_width = 2'd1;
        do_reset();
        push(16'h2ABC);
        slave_frame(1'b1, 16, 16'h1235, seen);
        check("R5 slave 14-bit slot out", {16'b0, seen}, 32'h0000AAF0);
        check("R6 slave 14-bit in", {16'b0, rx_last}, 32'h0000048D);

        summary();
        $finish;
    end

endmodule